// File: doc/BRIEF.md
# Conversion Retry Guard

This block runs a sensing conversion made of a fixed number of equal-length phases. It repeats any phase that may have been disturbed by a heavily loaded output pin switching. Three output-activity sources can each be chosen for watching: a two-wire bus driver, an SPI driver and writes to a port register. When a watched source shows activity during a phase, that phase is marked corrupted. When the phase ends it is run again instead of being accepted. The analog front end and the result arithmetic are stood in for by the phase counter.

A cap on retries per conversion can be chosen: no limit, two, or four. With a cap in place, a conversion finishes even when watched outputs switch all the time. After the cap is reached, the conversion accepts any later corruption. A sticky event flag tells software that at least one retry has happened since the flag was last cleared.

Top module: `conv_retry_guard`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `evt_o` are 0. All watch enables are 0 and the cap mode is unlimited, so activity on any source causes no retry until a configuration write.
- R2: With no retries, `done_o` rises 128 cycles after the clock edge that samples `start_i` (8 phases of 16 cycles each). It is high for exactly one cycle, and `busy_o` is low while it is high.
- R3: A pulse on a watched `act_i` bit during a phase makes that phase repeat once it ends. Each retry delays `done_o` by 16 cycles.
- R4: Activity on a source whose watch bit is 0 has no effect on the conversion length or on `evt_o`.
- R5: The cap field encodes 00 as unlimited, 01 as at most two retries and 1x as at most four retries per conversion. Activity after the cap is reached causes no retry.
- R6: The retry count clears at each accepted start, so the cap applies to each conversion separately.
- R7: `evt_o` is set by any retry. It stays set until a cycle with `evt_clr_i` high and no retry, and then it reads 0.
- R8: When `evt_clr_i` is high in the same cycle as a retry, `evt_o` is 1 after that edge.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running conversion keeps its length and no extra `done_o` pulse follows.
- R10: A cycle with `cfg_wr_i` high loads the watch mask from `cfg_watch_i` and the cap mode from `cfg_cap_i`. In the mask, bit 0 is the two-wire bus, bit 1 is SPI and bit 2 is port writes; the same bit order applies to `act_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a conversion |
| act_i | input | 3 | Output-activity strobes: two-wire, SPI, port write |
| cfg_wr_i | input | 1 | Load strobe for watch mask and cap mode |
| cfg_watch_i | input | 3 | Watch-enable mask, same bit order as act_i |
| cfg_cap_i | input | 2 | Retry cap mode |
| evt_clr_i | input | 1 | Software clear of the event flag |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| evt_o | output | 1 | Sticky retry-event flag |

## Verification
A wrong phase or cycle count shows up directly as a shift in when `done_o` arrives: a lost retry makes the conversion 16 cycles early and a spurious one makes it 16 cycles late. Every conversion is checked to the exact cycle. A retry counter that does not clear, or a cap that is decoded wrongly, shows up in the second of two back-to-back capped conversions or in the first capped one. An event flag that mishandles the set and clear order is wrong on the cycle after the shared edge.

// File: rtl/conv_retry_guard.sv
module conv_retry_guard #(
  parameter int NSRC      = 3,
  parameter int NPHASE    = 8,
  parameter int PHASE_CYC = 16,
  parameter int RW        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NSRC-1:0] act_i,
  input  logic            cfg_wr_i,
  input  logic [NSRC-1:0] cfg_watch_i,
  input  logic [1:0]      cfg_cap_i,
  input  logic            evt_clr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            evt_o
);
  localparam int PW = (NPHASE > 1) ? $clog2(NPHASE) : 1;
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic            busy_q, done_q, evt_q, dirty_q;
  logic [NSRC-1:0] watch_q;
  logic [1:0]      cap_q;
  logic [PW-1:0]   phase_q;
  logic [CW-1:0]   cnt_q;
  logic [RW-1:0]   rtry_q;

  logic hit, allow, phase_end, corrupt, retry, last;

  assign hit       = |(act_i & watch_q);
  assign allow     = (cap_q == 2'b00) ? 1'b1 :
                     (cap_q == 2'b01) ? (rtry_q < RW'(2)) : (rtry_q < RW'(4));
  assign phase_end = busy_q && (cnt_q == CW'(PHASE_CYC - 1));
  assign corrupt   = dirty_q | (hit & allow);
  assign retry     = phase_end & corrupt;
  assign last      = (phase_q == PW'(NPHASE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      evt_q   <= 1'b0;
      dirty_q <= 1'b0;
      watch_q <= '0;
      cap_q   <= 2'b00;
      phase_q <= '0;
      cnt_q   <= '0;
      rtry_q  <= '0;
    end else begin
      if (cfg_wr_i) begin
        watch_q <= cfg_watch_i;
        cap_q   <= cfg_cap_i;
      end
      done_q <= phase_end && !corrupt && last;
      if (retry)          evt_q <= 1'b1;
      else if (evt_clr_i) evt_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          phase_q <= '0;
          cnt_q   <= '0;
          dirty_q <= 1'b0;
          rtry_q  <= '0;
        end
      end else if (phase_end) begin
        cnt_q   <= '0;
        dirty_q <= 1'b0;
        if (corrupt) begin
          if (rtry_q != '1) rtry_q <= rtry_q + 1'b1;
        end else if (last) begin
          busy_q <= 1'b0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (hit && allow) dirty_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign evt_o  = evt_q;
endmodule

module conv_retry_guard_chk #(
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          evt_clr_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          evt_o,
  input logic          retry,
  input logic [1:0]    cap,
  input logic [RW-1:0] rcnt
);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  assert_retry_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> busy_o);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> evt_o);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !evt_clr_i) |=> evt_o);
  assert_cap_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && cap == 2'b01) |-> (rcnt < RW'(2)));
  assert_cap_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && cap[1]) |-> (rcnt < RW'(4)));
endmodule

bind conv_retry_guard conv_retry_guard_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .evt_clr_i(evt_clr_i),
  .busy_o(busy_o), .done_o(done_o), .evt_o(evt_o),
  .retry(retry), .cap(cap_q), .rcnt(rtry_q)
);

// File: tb/sim_conv_retry_guard.sv
module sim_conv_retry_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cfg_wr_i = 1'b0, evt_clr_i = 1'b0;
  logic [2:0] act_i = '0, cfg_watch_i = '0;
  logic [1:0] cfg_cap_i = '0;
  logic busy_o, done_o, evt_o;

  always #5 clk = ~clk;

  conv_retry_guard u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .act_i(act_i),
    .cfg_wr_i(cfg_wr_i), .cfg_watch_i(cfg_watch_i), .cfg_cap_i(cfg_cap_i),
    .evt_clr_i(evt_clr_i), .busy_o(busy_o), .done_o(done_o), .evt_o(evt_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int q_cyc[$];
  bit q_evt[$];
  string q_tag[$];
  bit m_evt = 1'b0;
  logic [2:0] m_watch = '0;
  int m_cap = 1000;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q_cyc.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        int ec;
        bit ee;
        string t;
        ec = q_cyc.pop_front();
        ee = q_evt.pop_front();
        t  = q_tag.pop_front();
        chk(cyc == ec, {t, " done cycle"}, cyc, ec);
        chk(evt_o == ee, {t, " evt at done"}, evt_o, ee);
        chk(busy_o == 1'b0, "R2 busy low at done", busy_o, 0);
      end
    end
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] mask, input logic [1:0] cap);
    cfg_watch_i = mask; cfg_cap_i = cap; cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    m_watch = mask;
    m_cap = (cap == 2'b00) ? 1000 : (cap == 2'b01) ? 2 : 4;
  endtask

  task automatic clear_evt();
    evt_clr_i = 1'b1;
    @(negedge clk);
    evt_clr_i = 1'b0;
    m_evt = 1'b0;
    chk(evt_o == 1'b0, "R7 evt cleared", evt_o, 0);
  endtask

  task automatic run_conv(input int nhits, input logic [2:0] src,
                          input bit clr_at_retry, input bit extra_start,
                          input string tag);
    int s, k, r, ec;
    s = cyc;
    k = s + 1;
    r = (|(src & m_watch)) ? ((nhits < m_cap) ? nhits : m_cap) : 0;
    ec = k + 128 + 16 * r;
    if (r > 0) m_evt = 1'b1;
    q_cyc.push_back(ec); q_evt.push_back(m_evt); q_tag.push_back(tag);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < nhits; j++) begin
      wait_cyc(k + 3 + 16 * j);
      act_i = src;
      @(negedge clk);
      act_i = '0;
    end
    if (clr_at_retry) begin
      wait_cyc(k + 15);
      chk(evt_o == 1'b0, "R8 evt low before retry", evt_o, 0);
      evt_clr_i = 1'b1;
      @(negedge clk);
      evt_clr_i = 1'b0;
      chk(evt_o == 1'b1, "R8 set wins over clear", evt_o, 1);
    end
    if (extra_start) begin
      wait_cyc(k + 50);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R9 still busy", busy_o, 1);
    end
    wait_cyc(ec + 3);
    chk(busy_o == 1'b0 && done_o == 1'b0, {tag, " idle after done"}, busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    chk(evt_o == 1'b0, "R1 evt reset", evt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_conv(2, 3'b111, 1'b0, 1'b0, "R1 R2 default unwatched");
    cfg(3'b001, 2'b00);
    run_conv(1, 3'b010, 1'b0, 1'b0, "R4 R10 disabled source");
    chk(evt_o == 1'b0, "R4 evt untouched", evt_o, 0);
    run_conv(3, 3'b001, 1'b0, 1'b0, "R3 R10 unlimited three retries");
    repeat (10) @(negedge clk);
    chk(evt_o == 1'b1, "R7 sticky hold", evt_o, 1);
    clear_evt();
    cfg(3'b111, 2'b01);
    run_conv(4, 3'b100, 1'b0, 1'b0, "R5 cap two");
    run_conv(3, 3'b100, 1'b0, 1'b0, "R6 cap two again");
    cfg(3'b111, 2'b10);
    run_conv(6, 3'b010, 1'b0, 1'b0, "R5 cap four");
    cfg(3'b111, 2'b11);
    run_conv(5, 3'b001, 1'b0, 1'b0, "R5 cap code 11");
    clear_evt();
    cfg(3'b010, 2'b00);
    run_conv(1, 3'b010, 1'b1, 1'b0, "R8 clear at retry");
    run_conv(0, 3'b000, 1'b0, 1'b1, "R9 start while busy");
    repeat (5) @(negedge clk);
    chk(q_cyc.size() == 0, "R9 no pending done", q_cyc.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule